// File: doc/BRIEF.md
# Vector Rotate-Mask-Insert Unit

This block is the datapath of a vector rotate-and-mask operation on a 128-bit register. The vector is split into independent lanes, either 64-bit or 32-bit wide. For each lane, a control operand supplies three small fields: the start of a mask, the end of a mask, and a left-rotate count. The block rotates the source element left by that count and builds a contiguous mask between the two bounds. The mask wraps around the lane when the start lies beyond the end.

Two result modes are available. In merge mode, the rotated bits under the mask replace the matching bits of the old destination element, and the other bits of the old destination are kept. In plain mode, every bit outside the mask is cleared. The result is registered, so it appears one clock after the operands are applied. Instruction decode, operand fetch and writeback belong to the surrounding pipeline.

Field positions in the control operand are given in two forms. The big-endian form counts from 0 at the lane's most significant bit. The little-endian form is the usual index within the lane, from 0 at the least significant bit.

Top module: `vrot_mask_ins`

## Requirements
- R1: With esize_i = 0 the vector is two 64-bit lanes, lane k occupying bits [64k+63:64k] of every vector port. With esize_i = 1 it is four 32-bit lanes, lane k occupying bits [32k+31:32k]. Each lane is computed only from the same lane of src_i, ctl_i and dst_i.
- R2: In a 64-bit lane, the fields sit at these little-endian positions of the control lane. The mask start is bits [21:16]. The mask end is bits [13:8]. The rotate count is bits [5:0].
- R3: In a 32-bit lane, the fields sit at these little-endian positions of the control lane. The mask start is bits [20:16]. The mask end is bits [12:8]. The rotate count is bits [4:0].
- R4: The rotated value is the source lane rotated left by the count. A bit at little-endian index i moves to index (i + count) mod W, where W is the lane width.
- R5: When start b ≤ end e, the mask is set at big-endian positions b through e inclusive. These are the little-endian bits W-1-e through W-1-b.
- R6: When b > e, the mask wraps around. It is set at big-endian positions b through W-1 and 0 through e. In particular, b = e+1 gives a mask of all ones.
- R7: With insert_i = 1, each result lane is (rotated AND mask) OR (dst lane AND NOT mask).
- R8: With insert_i = 0, each result lane is rotated AND mask, and every bit outside the mask is zero.
- R9: Control bits outside the three fields of a lane have no effect on the result.
- R10: res_o presents the result of the operands applied one clock edge earlier. A synchronous active-high rst sets res_o to zero at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 128 | Source vector, rotated per lane |
| ctl_i | input | 128 | Control vector holding per-lane mask start, mask end and rotate count |
| dst_i | input | 128 | Old destination vector, merged in insert mode |
| esize_i | input | 1 | Lane size: 0 = 64-bit lanes, 1 = 32-bit lanes |
| insert_i | input | 1 | 1 = merge under mask with dst_i, 0 = clear outside mask |
| res_o | output | 128 | Registered result vector |

## Verification
The wrapped mask is the hardest case to reach from the ports. This includes its extreme, where the start sits one past the end and the mask becomes all ones. Random control words seldom place the start just beyond the end, and they almost never do so in both lane sizes. The stimulus therefore writes the start and end fields directly at their stated positions: one wrap across the lane edge, one exact all-ones wrap, and the same bounds placed in 32-bit lanes. A separate vector fills every non-field control bit with ones, to show that those bits have no effect.

// File: rtl/vrot_mask_ins_pkg.sv
package vrot_mask_ins_pkg;

  typedef enum logic {
    ESZ_64 = 1'b0,
    ESZ_32 = 1'b1
  } esz_e;

  // Big-endian position of the last bit of each control field, relative to lane width w.
  function automatic int beg_last(input int w);
    return w - 17;
  endfunction

  function automatic int end_last(input int w);
    return w - 9;
  endfunction

  function automatic int cnt_last(input int w);
    return w - 1;
  endfunction

  // Little-endian start index of a field whose big-endian last bit is p, in a lane of w bits.
  function automatic int le_start(input int w, input int p);
    return w - p - 1;
  endfunction

endpackage

// File: rtl/vrot_rotl.sv
module vrot_rotl #(
  parameter int W   = 64,
  parameter int CW  = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  input  logic [CW-1:0] amt_i,
  output logic [W-1:0]  rot_o
);

  logic [2*W-1:0] dbl;

  always_comb begin
    dbl   = {val_i, val_i} << amt_i;
    rot_o = dbl[2*W-1:W];
  end

endmodule

// File: rtl/vrot_mask_gen.sv
module vrot_mask_gen #(
  parameter int W  = 64,
  parameter int CW = $clog2(W)
) (
  input  logic [CW-1:0] beg_i,
  input  logic [CW-1:0] end_i,
  output logic [W-1:0]  mask_o
);

  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic [W-1:0] from_beg;   // big-endian positions beg..W-1
  logic [W-1:0] upto_end;   // big-endian positions 0..end
  logic         wraps;

  always_comb begin
    from_beg = ONES >> beg_i;
    upto_end = ~((ONES >> end_i) >> 1);
    wraps    = beg_i > end_i;
    mask_o   = wraps ? (from_beg | upto_end) : (from_beg & upto_end);
  end

endmodule

// File: rtl/vrot_lane.sv
module vrot_lane
  import vrot_mask_ins_pkg::*;
#(
  parameter int W  = 64,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] ctl_i,
  input  logic [W-1:0] dst_i,
  input  logic         insert_i,
  output logic [W-1:0] res_o
);

  localparam int BEG_LSB = le_start(W, beg_last(W));
  localparam int END_LSB = le_start(W, end_last(W));
  localparam int CNT_LSB = le_start(W, cnt_last(W));

  logic [CW-1:0] f_beg;
  logic [CW-1:0] f_end;
  logic [CW-1:0] f_cnt;
  logic [W-1:0]  rot;
  logic [W-1:0]  mask;
  logic          ctl_unused;

  assign f_beg      = ctl_i[BEG_LSB +: CW];
  assign f_end      = ctl_i[END_LSB +: CW];
  assign f_cnt      = ctl_i[CNT_LSB +: CW];
  assign ctl_unused = ^ctl_i;

  vrot_rotl #(.W(W), .CW(CW)) u_rotl (
    .val_i (src_i),
    .amt_i (f_cnt),
    .rot_o (rot)
  );

  vrot_mask_gen #(.W(W), .CW(CW)) u_mask (
    .beg_i  (f_beg),
    .end_i  (f_end),
    .mask_o (mask)
  );

  always_comb begin
    if (insert_i) res_o = (rot & mask) | (dst_i & ~mask);
    else          res_o = rot & mask;
  end

endmodule

// File: rtl/vrot_mask_ins.sv
module vrot_mask_ins
  import vrot_mask_ins_pkg::*;
#(
  parameter int VEC_W   = 128,
  parameter int WIDE_W  = 64,
  parameter int NARR_W  = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VEC_W-1:0] src_i,
  input  logic [VEC_W-1:0] ctl_i,
  input  logic [VEC_W-1:0] dst_i,
  input  logic             esize_i,
  input  logic             insert_i,
  output logic [VEC_W-1:0] res_o
);

  localparam int N_WIDE = VEC_W / WIDE_W;
  localparam int N_NARR = VEC_W / NARR_W;

  logic [VEC_W-1:0] res_wide;
  logic [VEC_W-1:0] res_narr;
  logic [VEC_W-1:0] res_sel;

  for (genvar g = 0; g < N_WIDE; g++) begin : g_wide
    vrot_lane #(.W(WIDE_W)) u_lane (
      .src_i    (src_i[g*WIDE_W +: WIDE_W]),
      .ctl_i    (ctl_i[g*WIDE_W +: WIDE_W]),
      .dst_i    (dst_i[g*WIDE_W +: WIDE_W]),
      .insert_i (insert_i),
      .res_o    (res_wide[g*WIDE_W +: WIDE_W])
    );
  end

  for (genvar g = 0; g < N_NARR; g++) begin : g_narr
    vrot_lane #(.W(NARR_W)) u_lane (
      .src_i    (src_i[g*NARR_W +: NARR_W]),
      .ctl_i    (ctl_i[g*NARR_W +: NARR_W]),
      .dst_i    (dst_i[g*NARR_W +: NARR_W]),
      .insert_i (insert_i),
      .res_o    (res_narr[g*NARR_W +: NARR_W])
    );
  end

  assign res_sel = (esz_e'(esize_i) == ESZ_32) ? res_narr : res_wide;

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) res_o <= '0;
      else     res_o <= res_sel;
    end
  end else begin : g_comb
    logic clk_unused;
    logic rst_unused;
    assign clk_unused = clk;
    assign rst_unused = rst;
    assign res_o      = res_sel;
  end

endmodule

// File: rtl/vrot_mask_ins_chk.sv
module vrot_mask_ins_chk #(
  parameter int VEC_W   = 128,
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic [VEC_W-1:0] src_i,
  input logic [VEC_W-1:0] dst_i,
  input logic             insert_i,
  input logic [VEC_W-1:0] res_o
);

  if (OUT_REG) begin : g_chk
    // R10: reset clears the output at the next edge
    p_reset_clear_r10: assert property (@(posedge clk) rst |=> (res_o == '0));

    // R8: plain mode with zero source yields zero
    p_zero_src_plain_r8: assert property (@(posedge clk) disable iff (rst)
      (!insert_i && src_i == '0) |=> (res_o == '0));

    // R8: rotate preserves ones and masking only removes them
    p_plain_no_new_ones_r8: assert property (@(posedge clk) disable iff (rst)
      !insert_i |=> ($countones(res_o) <= $countones($past(src_i))));

    // R7: merge with zero source only clears destination bits
    p_merge_zero_src_r7: assert property (@(posedge clk) disable iff (rst)
      (insert_i && src_i == '0) |=> ((res_o & ~$past(dst_i)) == '0));

    // R7: merge with all-ones source keeps every destination one
    p_merge_ones_src_r7: assert property (@(posedge clk) disable iff (rst)
      (insert_i && src_i == '1) |=> ((~res_o & $past(dst_i)) == '0));
  end

endmodule

bind vrot_mask_ins vrot_mask_ins_chk #(.VEC_W(VEC_W), .OUT_REG(OUT_REG)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .src_i    (src_i),
  .dst_i    (dst_i),
  .insert_i (insert_i),
  .res_o    (res_o)
);

// File: tb/vrot_mask_ins_bench.sv
module vrot_mask_ins_bench;

  logic         clk = 1'b0;
  logic         rst;
  logic [127:0] src_i, ctl_i, dst_i;
  logic         esize_i, insert_i;
  logic [127:0] res_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  vrot_mask_ins u_vrot_mask_ins (
    .clk(clk), .rst(rst), .src_i(src_i), .ctl_i(ctl_i), .dst_i(dst_i),
    .esize_i(esize_i), .insert_i(insert_i), .res_o(res_o)
  );

  // Reference built bit by bit from the requirements (big-endian walk).
  function automatic logic [127:0] model(input logic [127:0] s, input logic [127:0] c,
                                         input logic [127:0] d, input logic es,
                                         input logic ins);
    logic [127:0] r = '0;
    int w  = es ? 32 : 64;
    int fw = es ? 5 : 6;
    for (int l = 0; l < 128 / w; l++) begin
      int base = l * w;
      int b  = int'((c >> (base + 16)) & ((128'd1 << fw) - 1));
      int e  = int'((c >> (base + 8))  & ((128'd1 << fw) - 1));
      int ct = int'((c >> base)        & ((128'd1 << fw) - 1));
      for (int p = 0; p < w; p++) begin
        int  i  = w - 1 - p;
        bit  in_m = (b <= e) ? (p >= b && p <= e) : (p >= b || p <= e);
        bit  rb = s[base + ((i - ct + w) % w)];
        r[base + i] = in_m ? rb : (ins ? d[base + i] : 1'b0);
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] exp);
    n_chk++;
    if (res_o !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, res_o, exp);
    end
  endtask

  task automatic apply(input logic [127:0] s, input logic [127:0] c, input logic [127:0] d,
                       input logic es, input logic ins);
    @(negedge clk);
    src_i = s; ctl_i = c; dst_i = d; esize_i = es; insert_i = ins;
    @(negedge clk);
  endtask

  localparam int NV = 6;
  localparam logic [127:0] T_SRC [NV] = '{
    128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
    128'hDEAD_BEEF_CAFE_F00D_0BAD_F00D_1234_5678,
    128'hA5A5_5A5A_0F0F_F0F0_3C3C_C3C3_9696_6969,
    128'h8000_0000_0000_0001_8000_0001_7FFF_FFFE,
    128'hFFFF_0000_FFFF_0000_1357_9BDF_2468_ACE0,
    128'h0000_0000_0000_0000_FFFF_FFFF_FFFF_FFFF
  };
  localparam logic [127:0] T_CTL [NV] = '{
    128'h0000_0000_0010_2F07_0000_0000_0030_0539,
    128'h0000_0000_003A_1011_0000_0000_0000_3F3F,
    128'h0001_1F03_0014_0A1D_0003_1C00_001E_021F,
    128'h0000_0000_0020_1F01_0000_0000_0005_2A20,
    128'hFFFF_FFFF_FFC2_C8C3_1234_5678_9A2B_3CC4,
    128'h0000_0000_0005_0400_0000_0000_0000_3F00
  };
  localparam logic [127:0] T_DST [NV] = '{
    128'h1111_2222_3333_4444_5555_6666_7777_8888,
    128'hFFFF_FFFF_FFFF_FFFF_0000_0000_0000_0000,
    128'h0F0F_0F0F_F0F0_F0F0_AAAA_AAAA_5555_5555,
    128'h0000_0000_0000_0000_0000_0000_0000_0000,
    128'hCCCC_3333_CCCC_3333_9999_6666_9999_6666,
    128'hFFFF_FFFF_FFFF_FFFF_0000_0000_0000_0000
  };
  localparam logic T_ES  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic T_INS [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; src_i = '1; ctl_i = 128'h3F00; dst_i = '1; esize_i = 1'b0; insert_i = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R10 reset", 128'h0);
    rst = 1'b0;

    // Table walk: R1 lane split, R7 merge, R8 plain, R9 ignored bits (entry 4)
    for (int k = 0; k < NV; k++) begin
      apply(T_SRC[k], T_CTL[k], T_DST[k], T_ES[k], T_INS[k]);
      check($sformatf("R1/R7/R8 table %0d", k),
            model(T_SRC[k], T_CTL[k], T_DST[k], T_ES[k], T_INS[k]));
    end

    // R4 rotate: full mask, counts 4 and 1 in the two 64-bit lanes
    apply({64'h8000_0000_0000_0000, 64'h1}, {64'h3F01, 64'h3F04}, '0, 1'b0, 1'b0);
    check("R4 rotate left", {64'h1, 64'h10});

    // R2/R5 start 56 end 63 on all ones -> low byte
    apply('1, {64'h38_3F00, 64'h38_3F00}, '0, 1'b0, 1'b0);
    check("R2 R5 mask 56..63", {64'hFF, 64'hFF});

    // R6 wrap: start 60 end 3
    apply('1, {64'h3C_0300, 64'h3C_0300}, '0, 1'b0, 1'b0);
    check("R6 wrap", {2{64'hF000_0000_0000_000F}});

    // R6 start = end + 1 -> all ones
    apply('1, {64'h0A_0900, 64'h0A_0900}, '0, 1'b0, 1'b0);
    check("R6 all ones", '1);

    // R7 merge: zero source into all-ones destination, mask low byte
    apply('0, {64'h38_3F00, 64'h38_3F00}, '1, 1'b0, 1'b1);
    check("R7 merge", {2{64'hFFFF_FFFF_FFFF_FF00}});

    // R3 32-bit lanes: start 24 end 31
    apply('1, {4{32'h0018_1F00}}, '0, 1'b1, 1'b0);
    check("R3 narrow fields", {4{32'h0000_00FF}});

    // R3 32-bit wrap start = end + 1 (start 5 end 4)
    apply('1, {4{32'h0005_0400}}, '0, 1'b1, 1'b0);
    check("R3 narrow all ones", '1);

    // R9 every non-field control bit set
    apply('1, {2{64'hFFFF_FFFF_FFC0_C0C0 | 64'h38_3F00}}, '0, 1'b0, 1'b0);
    check("R9 ignored bits", {64'hFF, 64'hFF});

    // R8 plain mode: bits outside mask cleared despite dst ones
    apply('1, {64'h38_3F00, 64'h38_3F00}, '1, 1'b0, 1'b0);
    check("R8 plain clears", {64'hFF, 64'hFF});

    // R10 synchronous reset after activity
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R10 sync reset", 128'h0);
    rst = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule